// File: doc/BRIEF.md
# Low-Frequency Carrier Edge and Gap Detector

This block watches the envelope of a low-frequency carrier, delivered as one 8-bit sample per carrier period from a peak-detecting front end. After reset it learns a baseline from the first 32 samples. It then runs measurements on request. Each measurement counts carrier periods until one of three things happens: a modulation edge is seen, the field drops to zero, or a limit is reached.

Edge detection uses a band of ±20 around the baseline. It also keeps a polarity flag, so the block looks alternately for a turn at a peak and a turn at a trough. Gap mode ends only on a sample of exactly zero. Wait mode only counts periods. The returned count gives the spacing in periods between modulation events, which upper layers use to recover bit timing. A measurement also ends with a count of zero on abort, when the period limit is reached, or when the sample stream goes silent.

Top module: `lf_edge_gap_detector`

## Requirements
- R1: After reset the block sums the first 32 valid samples. On the 32nd it sets `baseline` to the sum shifted right by 5 and loads the same value into the previous-sample register. Until then `baseline` reads 0, and `start` is ignored.
- R2: The upper threshold is baseline+20 and the lower threshold is baseline−20, both computed modulo 256.
- R3: In edge mode (`mode`=2'b00) with the polarity flag set, a sample ends the run with its period count when the previous sample is above the upper threshold and the current sample is ≤ the previous one. The flag then clears.
- R4: In edge mode with the polarity flag clear, a sample ends the run with its period count when the previous sample is below the lower threshold and the current sample is ≥ the previous one. The flag then sets.
- R5: Every comparison uses the sample from before the current one. During a run the previous-sample register takes each valid sample after it has been tested, and it keeps its value across runs.
- R6: In gap mode (`mode`=2'b01) the only event is a sample equal to 0. It ends the run with its period count and leaves the polarity flag unchanged.
- R7: In wait mode (`mode`=2'b10 or 2'b11) sample values are not tested, and the run ends only through R8, R9 or R12.
- R8: Each valid sample during a run adds one to the period count. If that count reaches `max_cnt` without an event, the run ends with a result of 0.
- R9: If IDLE_TICKS clock cycles (default 100000) pass in a run with no valid sample, the run ends with a result of 0. Each valid sample restarts this window.
- R10: `clr` pulsed while idle clears the polarity flag and sets the previous-sample register to 0xFF.
- R11: `rdr_mod` shows the polarity flag and `tag_mod` shows its inverse. After reset they read 0 and 1.
- R12: `abort` during a run ends it on the next cycle with a result of 0.
- R13: `done` is a one-cycle pulse in the cycle after the ending event, with `count` holding the result until the next `done`. A `start` during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a measurement |
| mode | input | 2 | 00 edge, 01 gap, 1x wait |
| max_cnt | input | 16 | Period limit |
| abort | input | 1 | End the current run with result 0 |
| clr | input | 1 | Reset polarity flag and previous sample |
| smp_vld | input | 1 | Sample strobe, one per carrier period |
| smp | input | 8 | Envelope sample |
| done | output | 1 | Run finished pulse |
| count | output | 16 | Result of the last run |
| tag_mod | output | 1 | Inverse of the polarity flag |
| rdr_mod | output | 1 | Polarity flag |
| baseline | output | 8 | Calibrated average |

## Verification
The hardest case to reach from the ports is one where the result depends on a previous-sample value left behind by an earlier run or by `clr`, and not by samples in the current run. The stimulus chains runs so that the first sample of a run is tested against the carried-over value. The sequence is: a trough edge that leaves 65, then a `clr`, then samples 70 and 75. With the 0xFF seed the run must return 2, where a stale register would give 1. The peak rule is pushed to its equality boundary by repeating a sample. A `start` pulse for a different mode is given in the middle of a run to confirm that it is ignored.

// File: rtl/lf_edge_gap_detector.sv
module lf_edge_gap_detector #(
  parameter int SMP_W      = 8,
  parameter int CNT_W      = 16,
  parameter int CAL_LOG2   = 5,
  parameter int BAND       = 20,
  parameter int IDLE_TICKS = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] max_cnt,
  input  logic             abort,
  input  logic             clr,
  input  logic             smp_vld,
  input  logic [SMP_W-1:0] smp,
  output logic             done,
  output logic [CNT_W-1:0] count,
  output logic             tag_mod,
  output logic             rdr_mod,
  output logic [SMP_W-1:0] baseline
);
  localparam int CAL_N  = 1 << CAL_LOG2;
  localparam int SUM_W  = SMP_W + CAL_LOG2;
  localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
  localparam logic [1:0] M_EDGE = 2'b00;
  localparam logic [1:0] M_GAP  = 2'b01;

  logic                cal_done;
  logic [CAL_LOG2-1:0] cal_cnt;
  logic [SUM_W-1:0]    sum;
  logic                busy, pol;
  logic [1:0]          mode_q;
  logic [CNT_W-1:0]    max_q, cnt;
  logic [IDLE_W-1:0]   idle;
  logic [SMP_W-1:0]    prev;

  wire [SUM_W-1:0] sum_n  = sum + SUM_W'(smp);
  wire [SMP_W-1:0] peak   = baseline + SMP_W'(BAND);
  wire [SMP_W-1:0] trough = baseline - SMP_W'(BAND);
  wire [CNT_W-1:0] cnt_n  = cnt + 1'b1;
  wire edge_hit = pol ? (prev > peak && smp <= prev) : (prev < trough && smp >= prev);
  wire hit = (mode_q == M_EDGE) ? edge_hit : (mode_q == M_GAP) ? (smp == '0) : 1'b0;

  assign rdr_mod = pol;
  assign tag_mod = ~pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_done <= 1'b0; cal_cnt <= '0; sum <= '0; baseline <= '0;
      busy <= 1'b0; pol <= 1'b0; mode_q <= M_EDGE; max_q <= '0;
      cnt <= '0; idle <= '0; prev <= '1; done <= 1'b0; count <= '0;
    end else begin
      done <= 1'b0;
      if (!cal_done) begin
        if (smp_vld) begin
          if (cal_cnt == CAL_LOG2'(CAL_N - 1)) begin
            baseline <= sum_n[SUM_W-1:CAL_LOG2];
            prev     <= sum_n[SUM_W-1:CAL_LOG2];
            cal_done <= 1'b1;
          end else begin
            sum     <= sum_n;
            cal_cnt <= cal_cnt + 1'b1;
          end
        end
      end else if (busy) begin
        if (abort) begin
          busy <= 1'b0; done <= 1'b1; count <= '0;
        end else if (smp_vld) begin
          cnt  <= cnt_n;
          idle <= '0;
          prev <= smp;
          if (hit) begin
            busy <= 1'b0; done <= 1'b1; count <= cnt_n;
            if (mode_q == M_EDGE) pol <= ~pol;
          end else if (cnt_n >= max_q) begin
            busy <= 1'b0; done <= 1'b1; count <= '0;
          end
        end else if (idle == IDLE_W'(IDLE_TICKS - 1)) begin
          busy <= 1'b0; done <= 1'b1; count <= '0;
        end else begin
          idle <= idle + 1'b1;
        end
      end else if (start) begin
        busy <= 1'b1; mode_q <= mode; max_q <= max_cnt; cnt <= '0; idle <= '0;
      end else if (clr) begin
        pol  <= 1'b0;
        prev <= '1;
      end
    end
  end

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_abort_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort) |=> (done && count == '0 && !busy));
  p_gap_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && smp_vld && mode_q == M_GAP && smp == '0)
      |=> (done && count == $past(cnt) + 1'b1 && $stable(pol)));
  p_wait_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && smp_vld && mode_q[1] && cnt + 1'b1 >= max_q) |=> (done && count == '0));
  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && !busy && !start && clr) |=> (tag_mod && prev == '1));
  p_pol_moves_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdr_mod) |-> (done || $past(clr)));
  p_start_ignored_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !abort && !smp_vld && start) |=> $stable(mode_q));
endmodule

// File: tb/lf_edge_gap_detector_tb_top.sv
module lf_edge_gap_detector_tb_top;
  logic clk = 0, rst_n = 0, start = 0, abort = 0, clr = 0, smp_vld = 0;
  logic [1:0] mode = 0;
  logic [15:0] max_cnt = 0;
  logic [7:0] smp = 0;
  logic done, tag_mod, rdr_mod;
  logic [15:0] count;
  logic [7:0] baseline;
  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  lf_edge_gap_detector #(.IDLE_TICKS(300)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .max_cnt(max_cnt),
    .abort(abort), .clr(clr), .smp_vld(smp_vld), .smp(smp), .done(done),
    .count(count), .tag_mod(tag_mod), .rdr_mod(rdr_mod), .baseline(baseline));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && done) begin
    if (exp_q.size() == 0) chk(0, "R13 unexpected done", count, -1);
    else begin
      automatic int e = exp_q.pop_front();
      automatic string r = req_q.pop_front();
      chk(count == e, r, count, e);
    end
  end

  task automatic send(input logic [7:0] v);
    @(posedge clk); #1 smp_vld = 1; smp = v;
    @(posedge clk); #1 smp_vld = 0;
  endtask

  task automatic run(input logic [1:0] m, input int mx, input int e, input string r);
    exp_q.push_back(e); req_q.push_back(r);
    @(posedge clk); #1 start = 1; mode = m; max_cnt = 16'(mx);
    @(posedge clk); #1 start = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 1000 && exp_q.size() != 0; i++) @(posedge clk);
    if (exp_q.size() != 0) begin
      chk(0, "missing done", exp_q.size(), 0);
      exp_q.delete(); req_q.delete();
    end
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    @(negedge clk);
    chk(done == 0 && count == 0, "R13 reset done/count", done, 0);
    chk(tag_mod == 1 && rdr_mod == 0, "R11 reset modulation", tag_mod, 1);
    chk(baseline == 0, "R1 reset baseline", baseline, 0);
    @(posedge clk); #1 start = 1; @(posedge clk); #1 start = 0;
    for (int i = 0; i < 31; i++) send((i % 2) ? 8'd101 : 8'd100);
    @(negedge clk); chk(baseline == 0, "R1 baseline before 32nd", baseline, 0);
    send(8'd101);
    @(negedge clk); chk(baseline == 100, "R1 baseline average", baseline, 100);
    // R4 trough edge, R2 lower threshold 80, R5 prior-sample use
    run(2'b00, 100, 4, "R4 trough edge count");
    send(100); send(70); send(60); send(65); drain();
    chk(rdr_mod == 1 && tag_mod == 0, "R4 flag set", rdr_mod, 1);
    // R10 clear, R5 carried previous sample
    @(posedge clk); #1 clr = 1; @(posedge clk); #1 clr = 0;
    @(negedge clk); chk(tag_mod == 1 && rdr_mod == 0, "R10 flag cleared", tag_mod, 1);
    run(2'b00, 100, 2, "R10 prev seeded 0xFF");
    send(70); send(75); drain();
    // R3 peak edge at equality, R2 upper threshold 120
    run(2'b00, 100, 3, "R3 peak edge equal");
    send(130); send(140); send(140); drain();
    chk(rdr_mod == 0, "R3 flag cleared", rdr_mod, 0);
    // R13 start during run ignored
    run(2'b00, 3, 3, "R13 start while busy");
    send(100);
    @(posedge clk); #1 start = 1; mode = 2'b01; max_cnt = 1; @(posedge clk); #1 start = 0;
    send(0); send(50); drain();
    // R8 edge mode limit without edge
    run(2'b00, 3, 0, "R8 limit in edge mode");
    send(100); send(100); send(100); drain();
    // R6 gap mode
    run(2'b01, 50, 3, "R6 gap zero");
    send(50); send(3); send(0); drain();
    chk(rdr_mod == 1, "R6 flag unchanged", rdr_mod, 1);
    // R7 wait mode ignores zeros, R8 limit
    run(2'b10, 5, 0, "R7 wait ignores values");
    for (int i = 0; i < 5; i++) send(0);
    drain();
    // R12 abort
    run(2'b00, 100, 0, "R12 abort");
    send(90);
    @(posedge clk); #1 abort = 1; @(posedge clk); #1 abort = 0;
    drain();
    // R9 idle timeout
    run(2'b01, 100, 0, "R9 idle timeout");
    send(40);
    repeat (290) @(posedge clk);
    chk(exp_q.size() == 1, "R9 not before window", exp_q.size(), 1);
    drain();
    chk(tag_mod == 0 && rdr_mod == 1, "R11 final modulation", tag_mod, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule